// File: doc/BRIEF.md
# Standard-Select Hunt Controller

This block drives a 2-bit select code to an external clock-recovery stage that can run at one of four serial data rates. While hunting, the code cycles 0, 1, 2, 3, 0, ... and stays on each value for a programmable number of clock cycles. The downstream deserializer pulses a timing-reference-found input when it sees a valid line sync. That pulse freezes the code and raises a locked indicator.

While locked, a watchdog counts the cycles since the last timing reference. If the programmable limit passes without a reference, the lock is dropped. Hunting then resumes from the code that was held, starting a fresh dwell period.

With the enable low, the block is parked: the code is 0 and the lock flag is low. Tying the enable low therefore turns automatic selection off, and the select outputs can be ignored.

Top module: `std_hunt_ctrl`

## Requirements
- R1: While reset (rst_n low) is asserted, sel_code is 0 and locked is 0.
- R2: While hunt_en is low, sel_code is 0 and locked is 0 from the next clock edge on, and ref_valid pulses do not raise locked.
- R3: While hunting, sel_code rises by one every dwell_cycles clock edges, counted from reset release, from enable or from loss of lock. After n edges the code is (n / dwell_cycles) mod 4.
- R4: The code wraps from 3 back to 0 and keeps cycling for as long as no timing reference arrives.
- R5: A dwell_cycles value of 0 behaves as 1, so the code steps on every edge.
- R6: A ref_valid pulse seen while hunting sets locked at that edge and freezes sel_code at its current value.
- R7: When ref_valid coincides with the last cycle of a dwell period, the code does not step. It is frozen at the value it had before that edge.
- R8: While locked, sel_code does not change, and each ref_valid restarts the lock timeout.
- R9: While locked, if lock_timeout edges pass with no ref_valid (a limit of 0 behaves as 1), locked falls. Hunting then restarts from the held code, and the next step comes dwell_cycles edges later.
- R10: Dropping hunt_en while locked clears locked and returns sel_code to 0. When hunt_en rises again, hunting restarts at code 0 with a full dwell period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hunt_en | input | 1 | Enables automatic hunting; low parks the code at 0 |
| dwell_cycles | input | DWELL_W | Cycles spent on each code while hunting (0 acts as 1) |
| lock_timeout | input | TMO_W | Cycles without a timing reference before the lock is dropped (0 acts as 1) |
| ref_valid | input | 1 | One-cycle pulse: a valid timing reference was found |
| sel_code | output | 2 | Standard-select code to the clock-recovery stage |
| locked | output | 1 | High while the code is frozen on a found standard |

## Verification
The hunt is run with dwell lengths of 0, 1, 3, 4 and 5 cycles. Each is sampled just before and just after a step boundary and across the wrap from 3 to 0. This separates off-by-one dwell counting and a zero limit taken literally from correct behaviour.

Timing references are applied in the middle of a dwell period and also on its final cycle. The second case shows whether a step slips through alongside the freeze.

While locked, periodic references are checked to keep the lock. A reference-free window is timed to the exact edge at which the lock falls, with both a normal limit and a zero limit. Enable-low cases show that references are ignored and that the code is parked at 0.

// File: rtl/std_hunt_pkg.sv
package std_hunt_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } hunt_state_t;

  // A programmed length of zero is treated as one cycle.
  function automatic logic [31:0] len_or_one(input logic [31:0] raw);
    return (raw == 32'd0) ? 32'd1 : raw;
  endfunction

  // Next select code in the hunt order; wraps naturally at the width.
  function automatic logic [1:0] next_sel(input logic [1:0] cur);
    return cur + 2'd1;
  endfunction

endpackage

// File: rtl/hunt_dwell_timer.sv
module hunt_dwell_timer #(
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [DWELL_W-1:0] limit,
  output logic               expire
);
  import std_hunt_pkg::*;

  localparam int LW = (DWELL_W > 32) ? 32 : DWELL_W;

  logic [DWELL_W-1:0] cnt;
  logic [DWELL_W-1:0] last_idx;

  always_comb begin
    last_idx = DWELL_W'(len_or_one(32'(limit[LW-1:0])) - 32'd1);
    expire   = run && (cnt == last_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (expire)  cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // The count never passes the last index while running.
  AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(limit)) |=> (cnt <= last_idx)); // R3

endmodule

// File: rtl/hunt_sel_counter.sv
module hunt_sel_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       park,
  input  logic       step,
  output logic [1:0] code
);
  import std_hunt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code <= 2'd0;
    else if (park)  code <= 2'd0;
    else if (step)  code <= next_sel(code);
  end

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !park) |=> (code == $past(code) + 2'd1)); // R4

  AST_NO_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !park) |=> $stable(code)); // R8

  AST_PARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> (code == 2'd0)); // R2

endmodule

// File: rtl/hunt_lock_watch.sv
module hunt_lock_watch #(
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             kick,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  import std_hunt_pkg::*;

  localparam int LW = (TMO_W > 32) ? 32 : TMO_W;

  logic [TMO_W-1:0] idle_cnt;
  logic [TMO_W-1:0] last_idx;

  always_comb begin
    last_idx = TMO_W'(len_or_one(32'(limit[LW-1:0])) - 32'd1);
    expire   = arm && !kick && (idle_cnt == last_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               idle_cnt <= '0;
    else if (!arm || kick)    idle_cnt <= '0;
    else if (!expire)         idle_cnt <= idle_cnt + 1'b1;
    else                      idle_cnt <= '0;
  end

  AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && kick) |=> (idle_cnt == '0)); // R8

endmodule

// File: rtl/std_hunt_ctrl.sv
module std_hunt_ctrl #(
  parameter int DWELL_W = 16,
  parameter int TMO_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hunt_en,
  input  logic [DWELL_W-1:0] dwell_cycles,
  input  logic [TMO_W-1:0]   lock_timeout,
  input  logic               ref_valid,
  output logic [1:0]         sel_code,
  output logic               locked
);
  import std_hunt_pkg::*;

  hunt_state_t state;

  // Named internal events, visible to the assertions.
  logic hunting;
  logic dwell_done;
  logic step_now;
  logic ref_hit;
  logic tmo_hit;

  assign hunting  = hunt_en && (state == ST_HUNT);
  assign ref_hit  = hunting && ref_valid;
  assign step_now = dwell_done && !ref_valid;

  hunt_dwell_timer #(.DWELL_W(DWELL_W)) u_dwell (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (hunting),
    .limit  (dwell_cycles),
    .expire (dwell_done)
  );

  hunt_sel_counter u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .park  (!hunt_en),
    .step  (step_now),
    .code  (sel_code)
  );

  hunt_lock_watch #(.TMO_W(TMO_W)) u_watch (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (hunt_en && (state == ST_LOCK)),
    .kick   (ref_valid),
    .limit  (lock_timeout),
    .expire (tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
    end else if (!hunt_en) begin
      state <= ST_HUNT;
    end else begin
      unique case (state)
        ST_HUNT: if (ref_hit) state <= ST_LOCK;
        ST_LOCK: if (tmo_hit) state <= ST_HUNT;
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign locked = (state == ST_LOCK);

  AST_EN_LOW_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    !hunt_en |=> (!locked && sel_code == 2'd0)); // R2

  AST_REF_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hit |=> (locked && $stable(sel_code))); // R6

  AST_COINCIDENT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && dwell_done) |=> $stable(sel_code)); // R7

  AST_LOCK_HOLDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && hunt_en) |=> $stable(sel_code)); // R8

  AST_TIMEOUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && hunt_en && tmo_hit) |=> !locked); // R9

  AST_NO_STEP_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !dwell_done); // R8

endmodule

// File: tb/std_hunt_ctrl_test.sv
module std_hunt_ctrl_test;

  localparam int DW = 16;
  localparam int TW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hunt_en = 1'b1;
  logic [DW-1:0] dwell_cycles = '0;
  logic [TW-1:0] lock_timeout = '0;
  logic          ref_valid = 1'b0;
  logic [1:0]    sel_code;
  logic          locked;

  int checks = 0;
  int bad = 0;

  always #10 clk = ~clk; // 50 MHz

  std_hunt_ctrl #(.DWELL_W(DW), .TMO_W(TW)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hunt_en      (hunt_en),
    .dwell_cycles (dwell_cycles),
    .lock_timeout (lock_timeout),
    .ref_valid    (ref_valid),
    .sel_code     (sel_code),
    .locked       (locked)
  );

  // dwell, edges after reset release, expected code
  localparam int NV = 10;
  localparam int VEC [NV][3] = '{
    '{3, 2, 0}, '{3, 3, 1}, '{3, 8, 2}, '{3, 9, 3}, '{3, 12, 0},
    '{1, 5, 1}, '{0, 6, 2}, '{5, 14, 2}, '{5, 15, 3}, '{4, 17, 0}
  };

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int dwell, input int tmo);
    @(negedge clk);
    rst_n = 1'b0;
    ref_valid = 1'b0;
    hunt_en = 1'b1;
    dwell_cycles = DW'(dwell);
    lock_timeout = TW'(tmo);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_ref();
    ref_valid = 1'b1;
    edges(1);
    ref_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    dwell_cycles = DW'(2);
    lock_timeout = TW'(8);
    edges(2);
    check("R1", sel_code, 0, "sel in reset");
    check("R1", locked, 0, "locked in reset");

    // R3 R4 R5: hunt sequence table
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][0], 100);
      edges(VEC[i][1]);
      check((VEC[i][0] == 0) ? "R5" : ((VEC[i][2] == 0 && VEC[i][1] > 4) ? "R4" : "R3"),
            sel_code, VEC[i][2], $sformatf("sel dwell=%0d n=%0d", VEC[i][0], VEC[i][1]));
      check("R3", locked, 0, "unlocked while hunting");
    end

    // R6: lock mid-dwell, R8 keepalive, R9 timeout
    do_reset(4, 8);
    edges(6);
    pulse_ref();
    check("R6", locked, 1, "locked after ref");
    check("R6", sel_code, 1, "code frozen at ref");
    for (int k = 0; k < 3; k++) begin
      edges(5);
      pulse_ref();
    end
    check("R8", locked, 1, "lock kept by refs");
    check("R8", sel_code, 1, "code held while locked");
    edges(7);
    check("R9", locked, 1, "still locked one edge before timeout");
    edges(1);
    check("R9", locked, 0, "lock dropped at timeout");
    check("R9", sel_code, 1, "code kept at unlock");
    edges(3);
    check("R9", sel_code, 1, "no step before new dwell ends");
    edges(1);
    check("R9", sel_code, 2, "step after fresh dwell");

    // R7: ref on the last dwell cycle
    do_reset(4, 50);
    edges(3);
    pulse_ref();
    check("R7", sel_code, 0, "no step with coincident ref");
    check("R7", locked, 1, "locked on coincident ref");

    // R10: enable drop while locked, then restart
    do_reset(4, 50);
    edges(5);
    pulse_ref();
    check("R10", sel_code, 1, "locked code before drop");
    hunt_en = 1'b0;
    edges(1);
    check("R10", sel_code, 0, "code parked on disable");
    check("R10", locked, 0, "lock cleared on disable");
    // R2: ref ignored while disabled
    pulse_ref();
    edges(3);
    check("R2", locked, 0, "ref ignored while disabled");
    check("R2", sel_code, 0, "code held at 0 while disabled");
    hunt_en = 1'b1;
    edges(3);
    check("R10", sel_code, 0, "no step before full dwell");
    edges(1);
    check("R10", sel_code, 1, "first step after re-enable");

    // R9: zero timeout behaves as one
    do_reset(3, 0);
    edges(1);
    pulse_ref();
    check("R9", locked, 1, "locked with zero timeout");
    edges(1);
    check("R9", locked, 0, "zero timeout drops after one edge");

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule